// File: doc/BRIEF.md
# AES-128 Round Key Scheduler

This block turns one 128-bit cipher key into the complete set of AES-128 round keys and keeps them in an internal table. A pipelined cipher datapath can then read any key at any time by round number. Expansion runs once after a start pulse. It produces one round key per clock, and a busy flag stays high until the table is full. While busy is high, the table contents must not be used.

The direction is chosen when expansion starts. In encrypt mode, table slot `i` holds round key `i`. In decrypt mode, the table holds the key set for the equivalent inverse cipher, in which the key addition follows the inverse column mix:

- The slots are filled in reverse order.
- Every key except the first and the last is passed through the inverse column-mix transform.

The datapath therefore reads slot 0, 1, 2 ... in both directions and never has to reorder anything.

Top module: `aes128_key_sched`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0 and `rk_out` is all-zero for every value of `rk_idx`.
- R2: When `start` is 1 while `busy` is 0, the key on `key_in` is taken and written unchanged to slot 0 if `decrypt` is 0, or to slot NR if `decrypt` is 1.
- R3: `busy` rises on the clock edge that accepts `start` and stays high for exactly NR clock cycles (10 by default). It then falls.
- R4: In encrypt mode, slot `i` holds round key `i` of the standard AES-128 schedule. Word 0 is `key[127:96]`, and byte 0 of each word is its top byte. Word 0 of round r is `SubWord(RotWord(w3 of round r-1))`, XORed with the round constant and with word 0 of round r-1. Word j > 0 is word j-1 of round r XORed with word j of round r-1. For key 2b7e151628aed2a6abf7158809cf4f3c, slot 10 reads d014f9a8c9ee2589e13f0cc8b6630ca6.
- R5: The round constants for rounds 1 to 10 are 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36. Each sits in the top byte of the word, with zeros in the lower bytes.
- R6: In decrypt mode, slot `i` holds the key derived from round NR-i. Slot 0 is the last round key and slot NR is the cipher key, and both are untransformed.
- R7: In decrypt mode, slots 1 to NR-1 hold the inverse column mix of their round key. Each 32-bit word is multiplied as a column by the matrix rows {0e,0b,0d,09} rotated.
- R8: `start`, `key_in` and `decrypt` are ignored while `busy` is 1. A second start during expansion changes neither the busy length nor any table entry.
- R9: Any `rk_idx` greater than NR reads as all-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin expansion; used only while idle |
| decrypt | input | 1 | 1 selects the decryption key set; sampled with start |
| key_in | input | 128 | Cipher key |
| busy | output | 1 | High while the table is being filled |
| rk_idx | input | IDX_W (4) | Round slot to read |
| rk_out | output | 128 | Contents of the selected slot, combinational |

## Verification
The bench builds the block with its default of ten rounds and a 4-bit index. This makes the standard FIPS key vector and the all-zero key vector directly comparable. With a 4-bit index, slots 11 to 15 exist on the port and can be read to show that out-of-range indexes give zero. The decryption keys in the middle slots are checked against an inverse column mix that the bench computes itself with a different multiplier structure. Restarting the block in the other direction shows that the same table is rewritten in place.

// File: rtl/aes_ks_pkg.sv
// Package: GF(2^8) arithmetic shared by the key scheduler.
// Assumes the AES field polynomial x^8+x^4+x^3+x+1.
// The S-box is computed rather than tabulated.
package aes_ks_pkg;

    // Multiply by x in the field.
    function automatic logic [7:0] gf_x2(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General field multiply, shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254; zero maps to zero.
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] p;
        logic [7:0] r;
        p = a;
        r = 8'h01;
        for (int i = 1; i < 8; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    // Forward S-box: inverse followed by the affine map with constant 63.
    function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
        logic [7:0] v;
        logic [7:0] o;
        v = gf_inv(a);
        for (int i = 0; i < 8; i++) begin
            o[i] = v[i] ^ v[(i + 4) % 8] ^ v[(i + 5) % 8] ^ v[(i + 6) % 8] ^ v[(i + 7) % 8];
        end
        return o ^ 8'h63;
    endfunction

endpackage

// File: rtl/aes_ks_ctrl.sv
// Module: sequencing for key expansion.
// Accepts start only when idle, then steps a round counter from 1 to NR,
// one round per clock, and keeps the matching round constant.
// Assumes NR >= 1.
module aes_ks_ctrl #(
    parameter int NR    = 10,
    parameter int IDX_W = $clog2(NR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load,
    output logic             busy,
    output logic [IDX_W-1:0] step,
    output logic [7:0]       rcon
);
    import aes_ks_pkg::*;

    typedef enum logic {ST_IDLE, ST_EXPAND} st_t;

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NR);

    st_t              st_q;
    logic [IDX_W-1:0] cnt_q;
    logic [7:0]       rcon_q;

    // Accept a start only while idle.
    assign load = start && (st_q == ST_IDLE);
    assign busy = (st_q == ST_EXPAND);
    assign step = cnt_q;
    assign rcon = rcon_q;

    // State, round counter and round constant register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            rcon_q <= 8'h01;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q   <= ST_EXPAND;
                        cnt_q  <= IDX_W'(1);
                        rcon_q <= 8'h01;
                    end
                end
                default: begin
                    cnt_q  <= cnt_q + IDX_W'(1);
                    rcon_q <= gf_x2(rcon_q);
                    if (cnt_q == LAST) st_q <= ST_IDLE;
                end
            endcase
        end
    end

    assert_busy_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    assert_busy_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt_q) == LAST));
    assert_step_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q >= IDX_W'(1) && cnt_q <= LAST));
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != LAST) |=> (busy && cnt_q == $past(cnt_q) + IDX_W'(1)));
    assert_rcon_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rcon_q == 8'h01));

endmodule

// File: rtl/aes_ks_round.sv
// Module: combinational step from one round key to the next.
// Uses four forward S-boxes on the rotated last word; the round constant
// is supplied by the controller.
module aes_ks_round (
    input  logic [127:0] prev_key,
    input  logic [7:0]   rcon,
    output logic [127:0] next_key
);
    import aes_ks_pkg::*;

    logic [31:0] last_w;
    logic [31:0] rot_w;
    logic [31:0] sub_w;
    logic [31:0] w0, w1, w2, w3;

    assign last_w = prev_key[31:0];
    assign rot_w  = {last_w[23:0], last_w[31:24]};

    // One substitution per byte of the rotated word.
    for (genvar b = 0; b < 4; b++) begin : g_sub
        assign sub_w[8*b +: 8] = sbox_fwd(rot_w[8*b +: 8]);
    end

    // Word chain within the new round.
    always_comb begin
        w0 = prev_key[127:96] ^ sub_w ^ {rcon, 24'h000000};
        w1 = prev_key[95:64] ^ w0;
        w2 = prev_key[63:32] ^ w1;
        w3 = prev_key[31:0]  ^ w2;
        next_key = {w0, w1, w2, w3};
    end

endmodule

// File: rtl/aes_ks_inv_mix.sv
// Module: inverse column mix over the four columns of a 128-bit key.
// Column c is bits [127-32c -: 32]; its top byte is row 0.
module aes_ks_inv_mix (
    input  logic [127:0] din,
    output logic [127:0] dout
);
    import aes_ks_pkg::*;

    for (genvar c = 0; c < 4; c++) begin : g_col
        logic [7:0] a0, a1, a2, a3;
        assign a0 = din[127-32*c -: 8];
        assign a1 = din[119-32*c -: 8];
        assign a2 = din[111-32*c -: 8];
        assign a3 = din[103-32*c -: 8];
        // Rows of the inverse matrix, each a rotation of {0e,0b,0d,09}.
        always_comb begin
            dout[127-32*c -: 8] = gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09);
            dout[119-32*c -: 8] = gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d);
            dout[111-32*c -: 8] = gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b);
            dout[103-32*c -: 8] = gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e);
        end
    end

endmodule

// File: rtl/aes_ks_table.sv
// Module: round key table with NR+1 slots, one write port and one
// combinational read port. Reads beyond slot NR return zero.
module aes_ks_table #(
    parameter int NR    = 10,
    parameter int IDX_W = $clog2(NR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [127:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [127:0]     rd_data
);
    localparam int DEPTH = NR + 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NR);

    logic [127:0] slot_q [DEPTH];

    // Slot storage: cleared by reset, one slot written per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            slot_q[wr_idx] <= wr_data;
        end
    end

    // Read mux with zero for out-of-range slots.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = slot_q[i];
        end
    end

    assert_wr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx <= LAST));
    assert_oob_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx > LAST) |-> (rd_data == '0));

endmodule

// File: rtl/aes128_key_sched.sv
// Module: top of the AES-128 round key scheduler.
// Fills the table with the encryption schedule, or with the equivalent
// inverse schedule (reversed, middle keys inverse-mixed), one key per clock.
// Assumes the consumer waits for busy low before reading.
module aes128_key_sched #(
    parameter int NR    = 10,
    parameter int IDX_W = $clog2(NR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             decrypt,
    input  logic [127:0]     key_in,
    output logic             busy,
    input  logic [IDX_W-1:0] rk_idx,
    output logic [127:0]     rk_out
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NR);

    logic             load;
    logic [IDX_W-1:0] step;
    logic [7:0]       rcon;
    logic [127:0]     prev_q;
    logic             dec_q;
    logic [127:0]     next_key;
    logic [127:0]     mixed_key;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [127:0]     wr_data;

    aes_ks_ctrl #(.NR(NR), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load(load), .busy(busy), .step(step), .rcon(rcon)
    );

    aes_ks_round u_round (.prev_key(prev_q), .rcon(rcon), .next_key(next_key));

    aes_ks_inv_mix u_imix (.din(next_key), .dout(mixed_key));

    // Previous-round register and direction latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            dec_q  <= 1'b0;
        end else if (load) begin
            prev_q <= key_in;
            dec_q  <= decrypt;
        end else if (busy) begin
            prev_q <= next_key;
        end
    end

    // Table write selection: slot order and transform depend on direction.
    always_comb begin
        wr_en = load || busy;
        if (load) begin
            wr_idx  = decrypt ? LAST : '0;
            wr_data = key_in;
        end else begin
            wr_idx  = dec_q ? (LAST - step) : step;
            wr_data = (dec_q && step != LAST) ? mixed_key : next_key;
        end
    end

    aes_ks_table #(.NR(NR), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rk_idx), .rd_data(rk_out)
    );

    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dec_q));
    assert_first_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (prev_q == $past(key_in)));
    assert_dec_edge_slots_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dec_q && step == LAST) |-> (wr_idx == '0 && wr_data == next_key));

endmodule

// File: tb/aes128_key_sched_test.sv
module aes128_key_sched_test;
    localparam int NR = 10;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          decrypt = 1'b0;
    logic [127:0]  key_in = '0;
    logic          busy;
    logic [IW-1:0] rk_idx = '0;
    logic [127:0]  rk_out;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    aes128_key_sched #(.NR(NR), .IDX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
        .key_in(key_in), .busy(busy), .rk_idx(rk_idx), .rk_out(rk_out)
    );

    localparam logic [127:0] KEY_A = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] KEY_Z = 128'h0;

    localparam logic [127:0] RK_A [11] = '{
        128'h2b7e151628aed2a6abf7158809cf4f3c, 128'ha0fafe1788542cb123a339392a6c7605,
        128'hf2c295f27a96b9435935807a7359f67f, 128'h3d80477d4716fe3e1e237e446d7a883b,
        128'hef44a541a8525b7fb671253bdb0bad00, 128'hd4d1c6f87c839d87caf2b8bc11f915bc,
        128'h6d88a37a110b3efddbf98641ca0093fd, 128'h4e54f70e5f5fc9f384a64fb24ea6dc4f,
        128'head27321b58dbad2312bf5607f8d292f, 128'hac7766f319fadc2128d12941575c006e,
        128'hd014f9a8c9ee2589e13f0cc8b6630ca6};

    typedef struct packed {
        logic [127:0] key;
        logic [3:0]   idx;
        logic         dec;
        logic [127:0] exp;
    } vec_t;

    // Vectors: key, slot, direction, expected slot contents (R4, R5, R6).
    localparam vec_t VECS [18] = '{
        '{KEY_A, 4'd0,  1'b0, 128'h2b7e151628aed2a6abf7158809cf4f3c},
        '{KEY_A, 4'd1,  1'b0, 128'ha0fafe1788542cb123a339392a6c7605},
        '{KEY_A, 4'd2,  1'b0, 128'hf2c295f27a96b9435935807a7359f67f},
        '{KEY_A, 4'd3,  1'b0, 128'h3d80477d4716fe3e1e237e446d7a883b},
        '{KEY_A, 4'd4,  1'b0, 128'hef44a541a8525b7fb671253bdb0bad00},
        '{KEY_A, 4'd5,  1'b0, 128'hd4d1c6f87c839d87caf2b8bc11f915bc},
        '{KEY_A, 4'd6,  1'b0, 128'h6d88a37a110b3efddbf98641ca0093fd},
        '{KEY_A, 4'd7,  1'b0, 128'h4e54f70e5f5fc9f384a64fb24ea6dc4f},
        '{KEY_A, 4'd8,  1'b0, 128'head27321b58dbad2312bf5607f8d292f},
        '{KEY_A, 4'd9,  1'b0, 128'hac7766f319fadc2128d12941575c006e},
        '{KEY_A, 4'd10, 1'b0, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6},
        '{KEY_A, 4'd0,  1'b1, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6},
        '{KEY_A, 4'd10, 1'b1, 128'h2b7e151628aed2a6abf7158809cf4f3c},
        '{KEY_Z, 4'd0,  1'b0, 128'h00000000000000000000000000000000},
        '{KEY_Z, 4'd1,  1'b0, 128'h62636363626363636263636362636363},
        '{KEY_Z, 4'd2,  1'b0, 128'h9b9898c9f9fbfbaa9b9898c9f9fbfbaa},
        '{KEY_Z, 4'd10, 1'b0, 128'hb4ef5bcb3e92e21123e951cf6f8f188e},
        '{KEY_Z, 4'd0,  1'b1, 128'hb4ef5bcb3e92e21123e951cf6f8f188e}};

    function automatic logic [7:0] xt(input logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
    endfunction

    // Independent inverse column mix built from doublings.
    function automatic logic [127:0] ref_imc(input logic [127:0] k);
        logic [127:0] o;
        logic [7:0] a [4];
        logic [7:0] m9 [4], mb [4], md [4], me [4];
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                logic [7:0] x2, x4, x8;
                a[r] = k[127 - 32*c - 8*r -: 8];
                x2 = xt(a[r]); x4 = xt(x2); x8 = xt(x4);
                m9[r] = x8 ^ a[r];
                mb[r] = x8 ^ x2 ^ a[r];
                md[r] = x8 ^ x4 ^ a[r];
                me[r] = x8 ^ x4 ^ x2;
            end
            for (int r = 0; r < 4; r++) begin
                o[127 - 32*c - 8*r -: 8] = me[r] ^ mb[(r+1)%4] ^ md[(r+2)%4] ^ m9[(r+3)%4];
            end
        end
        return o;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_slot(input int i, output logic [127:0] v);
        @(negedge clk);
        rk_idx = IW'(i);
        #1;
        v = rk_out;
    endtask

    // Pulse start, optionally a disturbing start mid-run; returns busy length.
    task automatic expand(input logic [127:0] k, input logic d, input bit disturb, output int len);
        @(negedge clk);
        start = 1'b1; key_in = k; decrypt = d;
        @(negedge clk);
        start = 1'b0; key_in = '0; decrypt = 1'b0;
        len = 0;
        while (busy === 1'b1 && len < 50) begin
            len++;
            if (disturb && len == 3) begin
                start = 1'b1; key_in = ~k; decrypt = ~d;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] v;
        int len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 busy after reset", {127'b0, busy}, 128'h0);
        read_slot(0, v);  chk("R1 slot0 after reset", v, '0);
        read_slot(10, v); chk("R1 slot10 after reset", v, '0);

        // R4 R5 R6: vector walk
        for (int i = 0; i < 18; i++) begin
            expand(VECS[i].key, VECS[i].dec, 1'b0, len);
            read_slot(int'(VECS[i].idx), v);
            chk($sformatf("R4/R6 vector %0d", i), v, VECS[i].exp);
        end

        // R3: busy length, R2: cipher key in slot 0
        expand(KEY_A, 1'b0, 1'b0, len);
        chk("R3 busy cycles", 128'(len), 128'(NR));
        read_slot(0, v); chk("R2 enc slot0", v, KEY_A);

        // R7: decrypt middle slots are inverse-mixed, reversed
        expand(KEY_A, 1'b1, 1'b0, len);
        chk("R3 busy cycles decrypt", 128'(len), 128'(NR));
        read_slot(10, v); chk("R2 dec slot NR", v, KEY_A);
        for (int i = 1; i < NR; i++) begin
            read_slot(i, v);
            chk($sformatf("R7 dec slot %0d", i), v, ref_imc(RK_A[NR - i]));
        end
        read_slot(0, v); chk("R6 dec slot0 untransformed", v, RK_A[10]);

        // R9: indexes past NR read zero
        read_slot(11, v); chk("R9 slot11", v, '0);
        read_slot(15, v); chk("R9 slot15", v, '0);

        // R8: start, key and mode during busy are ignored
        expand(KEY_A, 1'b0, 1'b1, len);
        chk("R8 busy length with second start", 128'(len), 128'(NR));
        read_slot(0, v);  chk("R8 slot0 kept", v, KEY_A);
        read_slot(5, v);  chk("R8 slot5 kept", v, RK_A[5]);
        read_slot(10, v); chk("R8 slot10 kept", v, RK_A[10]);
        @(negedge clk);
        chk("R8 idle after run", {127'b0, busy}, 128'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule